// File: doc/BRIEF.md
# Paged EEPROM Write Sequencer with Acknowledge Polling

This block writes a buffer of arbitrary length into a two-wire serial EEPROM. It sits above a byte-level bus master that carries out one command at a time (Start, Stop, or write one byte and report the acknowledge). The host gives a 19-bit target address, a byte count and a read port into the source buffer, then pulses `go`. The sequencer splits the transfer into chunks that never cross a 128-byte page boundary. It sends each chunk as one page write, then polls the device with acknowledge polling until the internal programming cycle has ended.

The control byte carries the fixed device code, the 64 KiB block bit (address bit 16) and two chip-select bits (address bits 17 and 18). Up to four devices with distinct straps therefore appear as one contiguous 512 KiB range. Polling reuses the control byte of the write that is still in progress. When the poll is acknowledged and more data remains, the sequencer continues on the same bus transaction if the next chunk needs the same control byte. Otherwise it issues a repeated Start with the new control byte. A device that never answers within a configurable number of polls, or a NACK during a write, ends the transfer with Stop and an error.

The states are IDLE, OPEN (Start), CTRL (control byte), AHI and ALO (address bytes), DATA, CLOSE (Stop that commits a page), PSTART and PCTRL (one poll), FIN (final Stop), ABORT (error Stop), DONE and FAIL. The transitions are:
- IDLE to OPEN on `go` with a nonzero length, or to DONE when the length is zero.
- OPEN to CTRL.
- CTRL to AHI to ALO to DATA, each on an acknowledge.
- DATA loops on itself until the last byte of the chunk, then goes to CLOSE.
- CLOSE to PSTART, and PSTART to PCTRL.
- PCTRL goes back to PSTART on a NACK, or to ABORT when the poll limit is reached. On an acknowledge it goes to FIN when no data remains, to AHI when the next chunk uses the same control byte, and to OPEN otherwise.
- Any NACK in CTRL, AHI, ALO or DATA leads to ABORT.
- FIN goes to DONE and ABORT goes to FAIL. Both DONE and FAIL return to IDLE.

Top module: `seq_ee_writer`

## Requirements
- R1: Each chunk is sent as Start, then the control byte (bits 7:4 = 1010, bit 3 = address bit 16, bit 2 = address bit 18, bit 1 = address bit 17, bit 0 = 0), then address bits 15:8, address bits 7:0, the data bytes in buffer order starting at index 0, then Stop. Command encoding on `cmd_op`: 00 Start, 01 Stop, 10 write byte.
- R2: No chunk contains bytes on both sides of an address that is a multiple of 128. A chunk ends at the next page boundary or at the end of the buffer.
- R3: Right after the Stop of a chunk, the sequencer sends Start plus the control byte. A NACK to that byte makes it send Start plus the control byte again, with no Stop in between.
- R4: The polling control byte is identical to the control byte of the chunk just written, even when the next chunk needs a different one.
- R5: The target address advances by one per data byte over all 19 bits. Crossing a 64 KiB boundary updates the block bit, and crossing a 128 KiB boundary updates the chip-select bits, in the next control byte.
- R6: When a poll is acknowledged and data remains, the next chunk starts directly with its address high byte if its control byte equals the polled one. Otherwise it starts with a repeated Start and the new control byte.
- R7: After POLL_LIMIT consecutive NACKed polls, the sequencer sends Stop and finishes with `err` = 1.
- R8: A NACK to the control, address or data byte of a write causes Stop next, with no further byte, and the transfer finishes with `err` = 1.
- R9: When the last poll is acknowledged and no data remains, the sequencer sends Stop and finishes with `err` = 0.
- R10: With a length of zero, `done` is high in the cycle after `go` and no bus command is issued.
- R11: A `go` pulse while `busy` is high has no effect on the command stream or the completion.
- R12: After reset `busy`, `done` and `cmd_valid` are low. `done` is a single-cycle pulse during which `busy` is high, and `busy` is low in the following cycle.
- R13: While `cmd_valid` is high and `cmd_done` has not yet been seen, `cmd_op` and `cmd_byte` stay constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Start pulse, taken only when idle |
| start_addr | input | 19 | First target byte address (chip select, block, word) |
| length | input | LEN_W | Number of bytes to write |
| rd_idx | output | LEN_W | Buffer index of the byte wanted next |
| rd_data | input | 8 | Buffer byte at `rd_idx` (combinational) |
| cmd_valid | output | 1 | Command request to the byte-level master |
| cmd_op | output | 2 | 00 Start, 01 Stop, 10 write byte |
| cmd_byte | output | 8 | Byte for a write command |
| cmd_done | input | 1 | One-cycle completion of the current command |
| cmd_nack | input | 1 | Device did not acknowledge (with `cmd_done`) |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | With `done`: transfer failed |

## Verification
The bench goes after chunk splitting at a page boundary, at a 64 KiB block boundary and at a 128 KiB chip-select boundary. A sequencer that split on the wrong boundary would emit too many or too few data bytes before Stop. One that fed the new address into the poll byte would poll a device or block that is not busy. The bench checks the fork after an acknowledged poll: it must continue directly when the control byte matches and use a repeated Start when it does not, so a single fixed path fails one of the two cases. It also covers a device that never answers, a NACK in the middle of the data, a zero length and a `go` during a transfer. These catch a missing retry bound, bytes sent after an abort, a hang on an empty buffer, and a second transfer started over the first.

// File: rtl/seq_ee_pkg.sv
package seq_ee_pkg;

    localparam int WORD_W = 16;
    localparam int ADDR_W = WORD_W + 3;
    localparam logic [3:0] DEV_CODE = 4'b1010;

    typedef enum logic [1:0] {
        OP_START = 2'b00,
        OP_STOP  = 2'b01,
        OP_WRITE = 2'b10
    } bus_op_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_OPEN,
        S_CTRL,
        S_AHI,
        S_ALO,
        S_DATA,
        S_CLOSE,
        S_PSTART,
        S_PCTRL,
        S_FIN,
        S_ABORT,
        S_DONE,
        S_FAIL
    } seq_state_e;

    function automatic logic [7:0] make_ctrl(input logic [ADDR_W-1:0] a);
        return {DEV_CODE, a[WORD_W], a[WORD_W+2], a[WORD_W+1], 1'b0};
    endfunction

endpackage

// File: rtl/seq_ee_chunk.sv
module seq_ee_chunk
    import seq_ee_pkg::*;
#(
    parameter int PAGE_BYTES = 128,
    parameter int LEN_W      = 16
) (
    input  logic [ADDR_W-1:0]              addr,
    input  logic [LEN_W-1:0]               remain,
    output logic [7:0]                     ctrl,
    output logic [$clog2(PAGE_BYTES):0]    chunk
);
    localparam int PAGE_W = $clog2(PAGE_BYTES);

    logic [PAGE_W:0]    room;
    logic [LEN_W-1:0]   room_ext;

    always_comb begin
        ctrl     = make_ctrl(addr);
        room     = (PAGE_W+1)'(PAGE_BYTES) - {1'b0, addr[PAGE_W-1:0]};
        room_ext = LEN_W'(room);
        chunk    = (remain < room_ext) ? remain[PAGE_W:0] : room;
    end

endmodule

// File: rtl/seq_ee_retry.sv
module seq_ee_retry #(
    parameter int LIMIT = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic bump,
    output logic last
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (clr)  cnt <= '0;
        else if (bump) cnt <= cnt + CW'(1);
    end

    assign last = (cnt == CW'(LIMIT - 1));

    assert_retry_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CW'(LIMIT));

endmodule

// File: rtl/seq_ee_writer.sv
module seq_ee_writer
    import seq_ee_pkg::*;
#(
    parameter int PAGE_BYTES = 128,
    parameter int LEN_W      = 16,
    parameter int POLL_LIMIT = 4096
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 go,
    input  logic [18:0]          start_addr,
    input  logic [LEN_W-1:0]     length,
    output logic [LEN_W-1:0]     rd_idx,
    input  logic [7:0]           rd_data,
    output logic                 cmd_valid,
    output logic [1:0]           cmd_op,
    output logic [7:0]           cmd_byte,
    input  logic                 cmd_done,
    input  logic                 cmd_nack,
    output logic                 busy,
    output logic                 done,
    output logic                 err
);
    localparam int PAGE_W = $clog2(PAGE_BYTES);

    seq_state_e           state, nxt;
    logic [ADDR_W-1:0]    cur_addr;
    logic [LEN_W-1:0]     remain;
    logic [PAGE_W:0]      chunk_left;
    logic [7:0]           poll_ctrl;
    logic [7:0]           ctrl_now;
    logic [PAGE_W:0]      chunk_sz;
    logic                 poll_last;
    logic                 poll_bump;
    logic                 acked;
    bus_op_e              op_q;

    seq_ee_chunk #(.PAGE_BYTES(PAGE_BYTES), .LEN_W(LEN_W)) u_chunk (
        .addr   (cur_addr),
        .remain (remain),
        .ctrl   (ctrl_now),
        .chunk  (chunk_sz)
    );

    assign acked     = cmd_done && !cmd_nack;
    assign poll_bump = (state == S_PCTRL) && cmd_done && cmd_nack && !poll_last;

    seq_ee_retry #(.LIMIT(POLL_LIMIT)) u_retry (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state == S_CLOSE),
        .bump  (poll_bump),
        .last  (poll_last)
    );

    // state register and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= S_IDLE;
            cur_addr   <= '0;
            remain     <= '0;
            rd_idx     <= '0;
            chunk_left <= '0;
            poll_ctrl  <= '0;
        end else begin
            state <= nxt;
            if (state == S_IDLE && go) begin
                cur_addr <= start_addr;
                remain   <= length;
                rd_idx   <= '0;
            end
            if (acked && state == S_CTRL)
                poll_ctrl <= ctrl_now;
            if (acked && (state == S_CTRL || state == S_PCTRL))
                chunk_left <= chunk_sz;
            if (acked && state == S_DATA) begin
                cur_addr   <= cur_addr + ADDR_W'(1);
                remain     <= remain - LEN_W'(1);
                rd_idx     <= rd_idx + LEN_W'(1);
                chunk_left <= chunk_left - (PAGE_W+1)'(1);
            end
        end
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:   if (go) nxt = (length == '0) ? S_DONE : S_OPEN;
            S_OPEN:   if (cmd_done) nxt = S_CTRL;
            S_CTRL:   if (cmd_done) nxt = cmd_nack ? S_ABORT : S_AHI;
            S_AHI:    if (cmd_done) nxt = cmd_nack ? S_ABORT : S_ALO;
            S_ALO:    if (cmd_done) nxt = cmd_nack ? S_ABORT : S_DATA;
            S_DATA: begin
                if (cmd_done) begin
                    if (cmd_nack)                              nxt = S_ABORT;
                    else if (chunk_left == (PAGE_W+1)'(1))     nxt = S_CLOSE;
                end
            end
            S_CLOSE:  if (cmd_done) nxt = S_PSTART;
            S_PSTART: if (cmd_done) nxt = S_PCTRL;
            S_PCTRL: begin
                if (cmd_done) begin
                    if (cmd_nack)                   nxt = poll_last ? S_ABORT : S_PSTART;
                    else if (remain == '0)          nxt = S_FIN;
                    else if (ctrl_now == poll_ctrl) nxt = S_AHI;
                    else                            nxt = S_OPEN;
                end
            end
            S_FIN:    if (cmd_done) nxt = S_DONE;
            S_ABORT:  if (cmd_done) nxt = S_FAIL;
            S_DONE:   nxt = S_IDLE;
            S_FAIL:   nxt = S_IDLE;
            default:  nxt = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cmd_valid = 1'b0;
        op_q      = OP_START;
        cmd_byte  = 8'h00;
        unique case (state)
            S_OPEN, S_PSTART: begin
                cmd_valid = 1'b1;
                op_q      = OP_START;
            end
            S_CTRL: begin
                cmd_valid = 1'b1;
                op_q      = OP_WRITE;
                cmd_byte  = ctrl_now;
            end
            S_AHI: begin
                cmd_valid = 1'b1;
                op_q      = OP_WRITE;
                cmd_byte  = cur_addr[15:8];
            end
            S_ALO: begin
                cmd_valid = 1'b1;
                op_q      = OP_WRITE;
                cmd_byte  = cur_addr[7:0];
            end
            S_DATA: begin
                cmd_valid = 1'b1;
                op_q      = OP_WRITE;
                cmd_byte  = rd_data;
            end
            S_PCTRL: begin
                cmd_valid = 1'b1;
                op_q      = OP_WRITE;
                cmd_byte  = poll_ctrl;
            end
            S_CLOSE, S_FIN, S_ABORT: begin
                cmd_valid = 1'b1;
                op_q      = OP_STOP;
            end
            default: begin
                cmd_valid = 1'b0;
            end
        endcase
        cmd_op = op_q;
        busy   = (state != S_IDLE);
        done   = (state == S_DONE) || (state == S_FAIL);
        err    = (state == S_FAIL);
    end

    assert_page_close_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DATA && acked && (&cur_addr[PAGE_W-1:0])) |=> (state == S_CLOSE));

    assert_poll_same_ctrl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PSTART || state == S_PCTRL) |-> $stable(poll_ctrl));

    assert_abort_on_nack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((state inside {S_CTRL, S_AHI, S_ALO, S_DATA}) && cmd_done && cmd_nack)
        |=> (state == S_ABORT));

    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    assert_cmd_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && $past(cmd_valid) && !$past(cmd_done))
        |-> ($stable(cmd_op) && $stable(cmd_byte)));

endmodule

// File: tb/tb_seq_ee_writer.sv
module tb_seq_ee_writer;
    localparam int LEN_W = 16;
    localparam int PL    = 6;
    localparam int LAT   = 3;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic              rst_n, go;
    logic [18:0]       start_addr;
    logic [LEN_W-1:0]  length;
    logic [LEN_W-1:0]  rd_idx;
    logic [7:0]        rd_data;
    logic              cmd_valid, cmd_done, cmd_nack, busy, done, err;
    logic [1:0]        cmd_op;
    logic [7:0]        cmd_byte;

    logic [7:0] mem [0:1023];
    assign rd_data = mem[rd_idx[9:0]];

    seq_ee_writer #(.PAGE_BYTES(128), .LEN_W(LEN_W), .POLL_LIMIT(PL)) dut (
        .clk(clk), .rst_n(rst_n), .go(go), .start_addr(start_addr), .length(length),
        .rd_idx(rd_idx), .rd_data(rd_data), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_byte(cmd_byte), .cmd_done(cmd_done), .cmd_nack(cmd_nack),
        .busy(busy), .done(done), .err(err)
    );

    int checks = 0, errors = 0;
    bit finished = 0;
    logic [9:0] expq [$];
    bit exp_err;
    string req;

    // device / byte-master model state
    int pending = 0, cnt = 0, pos = 0, busy_left = 0, dcount = 0;
    int poll_nacks = 0, nack_data_at = -1, captured = 0;
    bit wrote = 0, resp = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    function automatic logic [7:0] ctl(input logic [18:0] a);
        return {4'hA, a[16], a[18], a[17], 1'b0};
    endfunction

    // byte-level master and device model, compared against the expected stream
    always @(negedge clk) begin
        if (!rst_n) begin
            cmd_done = 0; cmd_nack = 0; pending = 0;
        end else if (cmd_done) begin
            cmd_done = 0; cmd_nack = 0;
        end else if (pending != 0) begin
            cnt--;
            if (cnt == 0) begin
                cmd_done = 1; cmd_nack = resp; pending = 0;
            end
        end else if (cmd_valid) begin
            captured++;
            if (expq.size() == 0) begin
                chk(0, req, "unexpected command", {cmd_op, cmd_byte}, 0);
            end else begin
                logic [9:0] e;
                e = expq.pop_front();
                chk({cmd_op, cmd_byte} == e, req, "command {op,byte}", {cmd_op, cmd_byte}, e);
            end
            resp = 0;
            if (cmd_op == 2'b00) pos = 0;
            else if (cmd_op == 2'b01) begin
                if (wrote) busy_left = poll_nacks;
                wrote = 0;
            end else begin
                if (pos == 0 && busy_left != 0) begin
                    resp = 1;
                    if (busy_left > 0) busy_left--;
                end else if (pos >= 3) begin
                    if (dcount == nack_data_at) resp = 1;
                    dcount++;
                    wrote = 1;
                end
                pos++;
            end
            pending = 1; cnt = LAT;
        end
    end

    // watchdog
    int cyc_total = 0;
    always @(negedge clk) begin
        cyc_total++;
        if (cyc_total > 190000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc_total, 190000);
            summary();
        end
    end

    task automatic build(input logic [18:0] a0, input int len, input int k, input int abort_at);
        logic [18:0] a;
        logic [7:0]  cp;
        int rem, idx, n;
        expq.delete();
        exp_err = 0;
        if (len == 0) return;
        a = a0; rem = len; idx = 0;
        expq.push_back({2'b00, 8'h00});
        expq.push_back({2'b10, ctl(a)});
        cp = ctl(a);
        forever begin
            expq.push_back({2'b10, a[15:8]});
            expq.push_back({2'b10, a[7:0]});
            n = 128 - int'(a[6:0]);
            if (rem < n) n = rem;
            for (int j = 0; j < n; j++) begin
                expq.push_back({2'b10, mem[idx]});
                if (idx == abort_at) begin
                    expq.push_back({2'b01, 8'h00});
                    exp_err = 1;
                    return;
                end
                idx++;
            end
            expq.push_back({2'b01, 8'h00});
            rem -= n;
            a = a + 19'(n);
            if (k < 0) begin
                for (int p = 0; p < PL; p++) begin
                    expq.push_back({2'b00, 8'h00});
                    expq.push_back({2'b10, cp});
                end
                expq.push_back({2'b01, 8'h00});
                exp_err = 1;
                return;
            end
            for (int p = 0; p <= k; p++) begin
                expq.push_back({2'b00, 8'h00});
                expq.push_back({2'b10, cp});
            end
            if (rem == 0) begin
                expq.push_back({2'b01, 8'h00});
                return;
            end
            if (ctl(a) != cp) begin
                cp = ctl(a);
                expq.push_back({2'b00, 8'h00});
                expq.push_back({2'b10, cp});
            end
        end
    endtask

    task automatic run(input string tag, input logic [18:0] a, input int len,
                       input int k, input int abort_at, input bit poke);
        int pulses, first;
        bit seen;
        req = tag;
        for (int i = 0; i < 1024; i++) mem[i] = 8'((i * 37 + len + 5) & 255);
        build(a, len, k, abort_at);
        busy_left = 0; dcount = 0; wrote = 0; pos = 0; captured = 0;
        poll_nacks = k; nack_data_at = abort_at;
        @(negedge clk);
        go = 1; start_addr = a; length = LEN_W'(len);
        pulses = 0; first = -1; seen = 0;
        for (int c = 0; c < 60000 && !seen; c++) begin
            @(negedge clk);
            if (c == 0) go = 0;
            if (poke && c == 20) begin
                go = 1; start_addr = 19'h00000; length = 16'd3;
            end
            if (poke && c == 21) go = 0;
            if (done) begin
                pulses++; first = c; seen = 1;
                chk(busy == 1'b1, "R12", "busy during done", busy, 1);
                chk(err == exp_err, tag, "err at done", err, exp_err);
            end
        end
        chk(seen, tag, "done observed", seen, 1);
        @(negedge clk);
        chk(!done && !busy, "R12", "done one cycle then idle", {done, busy}, 0);
        chk(expq.size() == 0, tag, "remaining expected commands", expq.size(), 0);
        repeat (8) @(negedge clk);
        chk(!cmd_valid && !done, "R11", "quiet after completion", {cmd_valid, done}, 0);
        if (len == 0) begin
            chk(first == 0, "R10", "done cycle after go", first, 0);
            chk(captured == 0, "R10", "commands for empty buffer", captured, 0);
        end
    endtask

    initial begin
        rst_n = 0; go = 0; start_addr = '0; length = '0;
        cmd_done = 0; cmd_nack = 0;
        repeat (4) @(negedge clk);
        chk(!busy && !done && !cmd_valid, "R12", "reset outputs",
            {busy, done, cmd_valid}, 0);
        rst_n = 1;
        @(negedge clk);
        // R1 R3 R9: single byte, two busy polls
        run("R1", 19'h00010, 1, 2, -1, 0);
        // R2 R6: page crossing, same control byte continues directly
        run("R2", 19'h0007C, 10, 1, -1, 0);
        // R4 R5 R6: 64 KiB block crossing on chip select 1, new control byte
        run("R5", 19'h2FFFE, 4, 1, -1, 0);
        // R4 R5: crossing into the next chip select
        run("R4", 19'h1FFFD, 5, 0, -1, 0);
        // R2: long buffer, three chunks
        run("R2", 19'h40000, 300, 0, -1, 0);
        // R7: device never answers
        run("R7", 19'h00100, 2, -1, -1, 0);
        // R8: NACK on third data byte
        run("R8", 19'h00200, 6, 0, 2, 0);
        // R10: empty buffer
        run("R10", 19'h00300, 0, 0, -1, 0);
        // R11: go while busy is ignored
        run("R11", 19'h00450, 20, 3, -1, 1);
        // R9 R13: stable commands exercised on a plain multi-page run
        run("R9", 19'h7FF80, 130, 0, -1, 0);
        summary();
    end

endmodule